// File: doc/BRIEF.md
# Halt State Bus Controller

This block records whether the processor sits in its halted state and shows that state on an active-low status output. The core reports two instruction events: a halt instruction and a sleep instruction. A configuration bit says whether standby is enabled. A sleep with standby disabled is handled like a halt. A sleep with standby enabled does not halt the processor; it raises a one-cycle request to the power sequencer, which lies outside this block.

The halted state ends only on an interrupt acknowledge or on reset. While halted, the block asks for the address and data buses to keep being driven. This drive request is withdrawn whenever an external master holds the bus grant. Refresh requests pass straight through, unless a grant is active, and never disturb the halted state.

All state changes happen on the falling edge of the bus clock. Reset is synchronous and active low, and it is sampled on that same edge.

Top module: `halt_bus_ctl`

## Requirements
- R1: While `rst_n` is low at a falling edge, the block ends up with `halt_n`=1, `stby_req`=0 and `bus_drive`=0. This holds even if it was halted before.
- R2: A `halt_ev` pulse sampled at a falling edge, with the block running, drives `halt_n` low from that edge on.
- R3: A `sleep_ev` pulse sampled with `stby_en`=0 enters the halted state in the same way as R2.
- R4: A `sleep_ev` pulse sampled with `stby_en`=1 while running leaves `halt_n` high. It raises `stby_req` for exactly one bus-clock period.
- R5: Once halted, `halt_n` stays low at every edge where `iack` is 0. Further `halt_ev` or `sleep_ev` pulses while halted have no effect, and in particular produce no `stby_req`.
- R6: An `iack` sampled while halted releases the halted state at that falling edge, so `halt_n` returns to 1. This holds even if `halt_ev` is high in the same cycle. An `iack` while running has no effect.
- R7: `bus_drive` is 1 exactly when the block is halted and `bgrant_act` is 0. The grant never changes `halt_n`.
- R8: `rfsh_go` equals `rfsh_req` while `bgrant_act` is 0 and is 0 while it is 1. A refresh request never changes `halt_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bus clock; state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_ev | input | 1 | Halt instruction executed (one-cycle pulse) |
| sleep_ev | input | 1 | Sleep instruction executed (one-cycle pulse) |
| stby_en | input | 1 | Standby mode enabled |
| iack | input | 1 | Interrupt acknowledge |
| rfsh_req | input | 1 | Refresh cycle requested |
| bgrant_act | input | 1 | Bus currently granted to another master |
| halt_n | output | 1 | Active-low halted status |
| bus_drive | output | 1 | Keep address/data buses driven |
| stby_req | output | 1 | One-cycle standby request |
| rfsh_go | output | 1 | Refresh may proceed |

## Verification
Two functions can coincide on one falling edge: an interrupt acknowledge that releases the halt, and a new halt instruction that would enter it. The bench raises `iack` and `halt_ev` together while halted, and expects `halt_n` high after that edge. This shows that the release takes precedence. A second overlap places a refresh request and an active bus grant in the same cycle while halted. The bench expects `rfsh_go` and `bus_drive` both low, with `halt_n` held low.

// File: rtl/hbc_pkg.sv
// Package: shared state encoding for the halt state bus controller.
// Assumes: a single bus clock domain, with state updated on its falling edge.
package hbc_pkg;
    typedef enum logic [0:0] {
        HBC_RUN  = 1'b0,
        HBC_HALT = 1'b1
    } hbc_state_e;
endpackage

// File: rtl/hbc_halt_fsm.sv
// Module: hbc_halt_fsm
// Tracks the run/halted state and produces the standby request pulse.
// Assumes: the event inputs are single-cycle pulses sampled on the falling
// edge of bclk; rst_n is synchronous and active low.
module hbc_halt_fsm
    import hbc_pkg::*;
(
    input  logic bclk,
    input  logic rst_n,
    input  logic halt_ev,
    input  logic sleep_ev,
    input  logic stby_en,
    input  logic iack,
    output logic halted,
    output logic stby_req
);
    hbc_state_e state_q, state_d;
    logic       stby_d;

    // Next-state choice: a release takes precedence over any entry event.
    always_comb begin
        state_d = state_q;
        stby_d  = 1'b0;
        unique case (state_q)
            HBC_RUN: begin
                if (halt_ev || (sleep_ev && !stby_en))
                    state_d = HBC_HALT;
                else if (sleep_ev && stby_en)
                    stby_d = 1'b1;
            end
            HBC_HALT: begin
                if (iack)
                    state_d = HBC_RUN;
            end
            default: state_d = HBC_RUN;
        endcase
    end

    // State and pulse registers, updated on the falling bus-clock edge.
    always_ff @(negedge bclk) begin
        if (!rst_n) begin
            state_q  <= HBC_RUN;
            stby_req <= 1'b0;
        end else begin
            state_q  <= state_d;
            stby_req <= stby_d;
        end
    end

    assign halted = (state_q == HBC_HALT);

    // R5
    hold_until_ack_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (halted && !iack) |=> halted);

    // R6
    ack_release_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (halted && iack) |=> !halted);

    // R2
    halt_entry_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (!halted && halt_ev) |=> halted);

    // R4
    stby_no_halt_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (!halted && sleep_ev && stby_en && !halt_ev) |=> (stby_req && !halted));

    // R4
    stby_single_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        stby_req |=> !stby_req);
endmodule

// File: rtl/hbc_bus_gate.sv
// Module: hbc_bus_gate
// Combines the halted state with the bus grant to decide on bus drive and
// refresh permission.
// Assumes: bgrant_act means that another master owns the bus right now.
module hbc_bus_gate (
    input  logic halted,
    input  logic bgrant_act,
    input  logic rfsh_req,
    output logic bus_drive,
    output logic rfsh_go
);
    // Drive and refresh gating: neither is allowed while the bus is granted.
    always_comb begin
        bus_drive = halted && !bgrant_act;
        rfsh_go   = rfsh_req && !bgrant_act;
    end
endmodule

// File: rtl/halt_bus_ctl.sv
// Module: halt_bus_ctl (top)
// Halt state bus controller: the halt FSM plus gating of the bus drive and
// of refresh.
// Assumes: all inputs are synchronous to bclk; reset is synchronous, active
// low, and sampled on the falling edge.
module halt_bus_ctl (
    input  logic bclk,
    input  logic rst_n,
    input  logic halt_ev,
    input  logic sleep_ev,
    input  logic stby_en,
    input  logic iack,
    input  logic rfsh_req,
    input  logic bgrant_act,
    output logic halt_n,
    output logic bus_drive,
    output logic stby_req,
    output logic rfsh_go
);
    logic halted;

    hbc_halt_fsm i_fsm (
        .bclk     (bclk),
        .rst_n    (rst_n),
        .halt_ev  (halt_ev),
        .sleep_ev (sleep_ev),
        .stby_en  (stby_en),
        .iack     (iack),
        .halted   (halted),
        .stby_req (stby_req)
    );

    hbc_bus_gate i_gate (
        .halted     (halted),
        .bgrant_act (bgrant_act),
        .rfsh_req   (rfsh_req),
        .bus_drive  (bus_drive),
        .rfsh_go    (rfsh_go)
    );

    // Status output: active-low copy of the halted state.
    always_comb halt_n = !halted;

    // R7
    grant_keeps_halt_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (!halt_n && bgrant_act && !iack) |=> !halt_n);

    // R8
    rfsh_no_effect_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (rfsh_req && !iack && !halt_ev && !sleep_ev) |=> $stable(halt_n));

    // R7
    drive_vs_grant_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        bgrant_act |-> !bus_drive);

    // R1
    reset_clear_chk: assert property (@(negedge bclk)
        !rst_n |=> (halt_n && !stby_req));
endmodule

// File: tb/test_halt_bus_ctl.sv
module test_halt_bus_ctl;
    localparam int CLK_P = 10;

    logic bclk = 1'b0;
    logic rst_n, halt_ev, sleep_ev, stby_en, iack, rfsh_req, bgrant_act;
    logic halt_n, bus_drive, stby_req, rfsh_go;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #(CLK_P/2) bclk = ~bclk;

    halt_bus_ctl i_halt_bus_ctl (
        .bclk(bclk), .rst_n(rst_n), .halt_ev(halt_ev), .sleep_ev(sleep_ev),
        .stby_en(stby_en), .iack(iack), .rfsh_req(rfsh_req),
        .bgrant_act(bgrant_act), .halt_n(halt_n), .bus_drive(bus_drive),
        .stby_req(stby_req), .rfsh_go(rfsh_go)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One period: returns just after the rising edge, so one falling edge has passed.
    task automatic cyc();
        @(posedge bclk);
        #1;
    endtask

    task automatic idle_inputs();
        halt_ev = 0; sleep_ev = 0; iack = 0; rfsh_req = 0; bgrant_act = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        stby_en = 0;
        rst_n = 0;
        cyc(); cyc();
        rst_n = 1;
    endtask

    task automatic enter_halt();
        halt_ev = 1; cyc(); halt_ev = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "halt_n", halt_n, 1'b1);
        chk("R1", "stby_req", stby_req, 1'b0);
        chk("R1", "bus_drive", bus_drive, 1'b0);
    endtask

    task automatic t_halt_entry();
        enter_halt();
        chk("R2", "halt_n after halt", halt_n, 1'b0);
        chk("R7", "bus_drive halted", bus_drive, 1'b1);
        iack = 1; cyc(); iack = 0;
    endtask

    task automatic t_sleep_halts();
        stby_en = 0; sleep_ev = 1; cyc(); sleep_ev = 0;
        chk("R3", "halt_n after sleep", halt_n, 1'b0);
        chk("R3", "stby_req", stby_req, 1'b0);
        iack = 1; cyc(); iack = 0;
    endtask

    task automatic t_sleep_standby();
        stby_en = 1; sleep_ev = 1; cyc(); sleep_ev = 0;
        chk("R4", "halt_n", halt_n, 1'b1);
        chk("R4", "stby_req pulse", stby_req, 1'b1);
        cyc();
        chk("R4", "stby_req ends", stby_req, 1'b0);
        stby_en = 0;
    endtask

    task automatic t_hold();
        enter_halt();
        for (int i = 0; i < 5; i++) cyc();
        chk("R5", "held", halt_n, 1'b0);
        stby_en = 1; sleep_ev = 1; cyc(); sleep_ev = 0;
        chk("R5", "sleep while halted no stby", stby_req, 1'b0);
        chk("R5", "still halted", halt_n, 1'b0);
        stby_en = 0;
    endtask

    task automatic t_release();
        iack = 1; cyc(); iack = 0;
        chk("R6", "released", halt_n, 1'b1);
        chk("R7", "no drive when running", bus_drive, 1'b0);
        iack = 1; cyc(); iack = 0;
        chk("R6", "iack while running", halt_n, 1'b1);
    endtask

    task automatic t_ack_vs_halt();
        enter_halt();
        iack = 1; halt_ev = 1; cyc(); iack = 0; halt_ev = 0;
        chk("R6", "iack beats halt_ev", halt_n, 1'b1);
    endtask

    task automatic t_grant();
        enter_halt();
        bgrant_act = 1; #1;
        chk("R7", "drive off under grant", bus_drive, 1'b0);
        cyc(); cyc();
        chk("R7", "halt kept under grant", halt_n, 1'b0);
        bgrant_act = 0; #1;
        chk("R7", "drive back", bus_drive, 1'b1);
    endtask

    task automatic t_refresh();
        rfsh_req = 1; #1;
        chk("R8", "rfsh_go pass", rfsh_go, 1'b1);
        cyc();
        chk("R8", "halt unchanged", halt_n, 1'b0);
        bgrant_act = 1; #1;
        chk("R8", "rfsh blocked by grant", rfsh_go, 1'b0);
        chk("R7", "drive off with grant+rfsh", bus_drive, 1'b0);
        cyc();
        chk("R8", "halt unchanged with grant", halt_n, 1'b0);
        idle_inputs();
    endtask

    task automatic t_reset_halted();
        rst_n = 0; cyc(); rst_n = 1;
        chk("R1", "reset clears halt", halt_n, 1'b1);
        chk("R1", "reset drive off", bus_drive, 1'b0);
    endtask

    initial begin
        t_reset();
        t_halt_entry();
        t_sleep_halts();
        t_sleep_standby();
        t_hold();
        t_release();
        t_ack_vs_halt();
        t_grant();
        t_refresh();
        t_reset_halted();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule